// File: doc/BRIEF.md
# Banked GPIO Controller with Event Interrupts

A memory-mapped general-purpose I/O controller for 70 pins, laid out as if for 96. Every per-pin setting is one bit inside a feature held across three 32-bit words, called banks. Pin `n` lives in bank `n / 32` at bit `n mod 32`. Software uses a word-addressed write port and a combinational read port to set direction and drive value, to choose one of four trigger modes per pin, and to arm interrupt enables.

Pin inputs pass through a two-flop synchronizer. From the synchronized value the block detects level or edge events and latches them into a status vector that software acknowledges by writing ones. A single interrupt line is the OR of status ANDed with the first of four enable sets. The other three enable sets are storage only and do not gate the interrupt.

Top module: `pinbank_irq_ctrl`

## Requirements
- R1: Word addresses are as follows: output enable 0x05, drive value 0x09, polarity 0x41, trigger type 0x45, status 0x49, and enable sets 0 to 3 at 0x11, 0x15, 0x19 and 0x1D. Bank k of a feature is at its base plus k, for k from 0 to 2. Any other address reads zero, and a write to it changes nothing.
- R2: Output-enable and drive-value words read back what was written. Bit n of `pin_oe` and `pin_out` equals pin n's stored bit.
- R3: Bits for pins 70 to 95 read as zero. Writes to those bits are ignored.
- R4: A pin value held at the input from one rising edge onward enters status on the third rising edge at which it is present. Edges compare the synchronized value with its value one cycle earlier.
- R5: The trigger mode is {type,polarity}. 00 selects high level, 01 low level, 10 rising edge and 11 falling edge.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A detected event in the same cycle wins over the clear.
- R7: For a level mode, status is set again on every cycle the active level persists. A clear during the level has no lasting effect.
- R8: `irq` is high exactly when some pin has both its status bit and its enable-set-0 bit set. Enable sets 1 to 3 never affect `irq`.
- R9: Synchronous active-high reset zeroes every register, the synchronizer, `pin_oe`, `pin_out` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_in | input | 70 | Asynchronous pin inputs |
| pin_oe | output | 70 | Per-pin output enable (1 = output) |
| pin_out | output | 70 | Per-pin drive value |
| irq | output | 1 | Combined interrupt |

## Verification
The bench times a rising edge on a single pin cycle by cycle. A synchronizer one stage short or long would set status one edge early or late. It clears a level-triggered pin while the level is still active and expects the bit to come back. A design that let the clear win would drop a pending level.

The bench also raises status with only enable set 1 armed. An interrupt that ORed all enable sets would then assert. It writes all ones to bank 2 and expects only six bits back. A design that stored the unused pins would return the extra bits.

Long random runs mix mode changes, acknowledges and pin toggles against a reference model. This exposes swapped polarity or type encodings and bit placements off by one bank.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int LAYOUT_PINS = 96;
    localparam int NBANKS      = LAYOUT_PINS / WORD_W;
    localparam int NSETS       = 4;
    localparam int SET_STRIDE  = 4;

    localparam logic [ADDR_W-1:0] OE_BASE   = 8'h05;
    localparam logic [ADDR_W-1:0] DRV_BASE  = 8'h09;
    localparam logic [ADDR_W-1:0] IEN_BASE  = 8'h11;
    localparam logic [ADDR_W-1:0] POL_BASE  = 8'h41;
    localparam logic [ADDR_W-1:0] TYP_BASE  = 8'h45;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h49;

    typedef enum logic [2:0] {
        FT_NONE, FT_OE, FT_DRV, FT_IEN, FT_POL, FT_TYP, FT_STAT
    } feat_e;

    // {type, polarity}
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    typedef struct packed {
        feat_e      feat;
        logic [1:0] set;
        logic [1:0] bank;
    } dec_t;

    function automatic logic in_feat(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
        return (a >= base) && (a < base + ADDR_W'(NBANKS));
    endfunction

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d = '{feat: FT_NONE, set: 2'd0, bank: 2'd0};
        if (in_feat(a, OE_BASE)) begin
            d.feat = FT_OE;   d.bank = 2'(a - OE_BASE);
        end else if (in_feat(a, DRV_BASE)) begin
            d.feat = FT_DRV;  d.bank = 2'(a - DRV_BASE);
        end else if (in_feat(a, POL_BASE)) begin
            d.feat = FT_POL;  d.bank = 2'(a - POL_BASE);
        end else if (in_feat(a, TYP_BASE)) begin
            d.feat = FT_TYP;  d.bank = 2'(a - TYP_BASE);
        end else if (in_feat(a, STAT_BASE)) begin
            d.feat = FT_STAT; d.bank = 2'(a - STAT_BASE);
        end
        for (int s = 0; s < NSETS; s++) begin
            if (in_feat(a, IEN_BASE + ADDR_W'(s * SET_STRIDE))) begin
                d.feat = FT_IEN;
                d.set  = 2'(s);
                d.bank = 2'(a - IEN_BASE - ADDR_W'(s * SET_STRIDE));
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q, cur_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/pbk_evdet.sv
module pbk_evdet
    import pbk_pkg::*;
#(
    parameter int W = 70
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_e mode;
        assign mode = trig_e'({typ[i], pol[i]});
        always_comb begin
            unique case (mode)
                TRIG_HIGH: evt[i] = cur[i];
                TRIG_LOW:  evt[i] = ~cur[i];
                TRIG_RISE: evt[i] = cur[i] & ~prev[i];
                TRIG_FALL: evt[i] = ~cur[i] & prev[i];
                default:   evt[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pbk_status.sv
module pbk_status #(
    parameter int W = 70
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] evt,
    output logic [W-1:0] stat
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & ~clr) | evt;
    end
endmodule

// File: rtl/pinbank_irq_ctrl.sv
module pinbank_irq_ctrl
    import pbk_pkg::*;
#(
    parameter int NUM_PINS = 70
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq
);
    dec_t dec;
    assign dec = decode(reg_addr);

    logic [NUM_PINS-1:0] wmask, wbits;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            wmask[i] = (2'(i / WORD_W) == dec.bank);
            wbits[i] = reg_wdata[i % WORD_W];
        end
    end

    logic [NUM_PINS-1:0] oe_q, drv_q, pol_q, typ_q, stat_q, evt, clr;
    logic [NSETS-1:0][NUM_PINS-1:0] ien_q;
    logic [NUM_PINS-1:0] s_cur, s_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= '0;
            drv_q <= '0;
            pol_q <= '0;
            typ_q <= '0;
            ien_q <= '0;
        end else if (reg_we) begin
            unique case (dec.feat)
                FT_OE:  oe_q  <= (oe_q  & ~wmask) | (wbits & wmask);
                FT_DRV: drv_q <= (drv_q & ~wmask) | (wbits & wmask);
                FT_POL: pol_q <= (pol_q & ~wmask) | (wbits & wmask);
                FT_TYP: typ_q <= (typ_q & ~wmask) | (wbits & wmask);
                FT_IEN: ien_q[dec.set] <= (ien_q[dec.set] & ~wmask) | (wbits & wmask);
                default: ;
            endcase
        end
    end

    assign clr = (reg_we && dec.feat == FT_STAT) ? (wbits & wmask) : '0;

    pbk_sync #(.W(NUM_PINS)) sync_i (
        .clk(clk), .rst(rst), .raw(pin_in), .cur(s_cur), .prev(s_prev)
    );

    pbk_evdet #(.W(NUM_PINS)) evdet_i (
        .cur(s_cur), .prev(s_prev), .typ(typ_q), .pol(pol_q), .evt(evt)
    );

    pbk_status #(.W(NUM_PINS)) status_i (
        .clk(clk), .rst(rst), .clr(clr), .evt(evt), .stat(stat_q)
    );

    logic [NUM_PINS-1:0]    sel;
    logic [LAYOUT_PINS-1:0] padded;
    always_comb begin
        unique case (dec.feat)
            FT_OE:   sel = oe_q;
            FT_DRV:  sel = drv_q;
            FT_POL:  sel = pol_q;
            FT_TYP:  sel = typ_q;
            FT_STAT: sel = stat_q;
            FT_IEN:  sel = ien_q[dec.set];
            default: sel = '0;
        endcase
        padded = '0;
        padded[NUM_PINS-1:0] = sel;
        reg_rdata = padded[int'(dec.bank) * WORD_W +: WORD_W];
    end

    assign pin_oe  = oe_q;
    assign pin_out = drv_q;
    assign irq     = |(stat_q & ien_q[0]);
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
    import pbk_pkg::*;
#(
    parameter int NUM_PINS = 70
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [WORD_W-1:0]   reg_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] stat_q,
    input logic [NUM_PINS-1:0] evt
);
    localparam int HI_BITS = NUM_PINS - 2 * WORD_W;
    localparam logic [WORD_W-1:0] HI_MASK = ~((WORD_W'(1) << HI_BITS) - WORD_W'(1));

    dec_t d;
    assign d = decode(reg_addr);

    // R3
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (d.feat != FT_NONE && d.bank == 2'd2) |-> ((reg_rdata & HI_MASK) == '0));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == STAT_BASE && evt[WORD_W-1:0] == '0)
        |=> ((stat_q[WORD_W-1:0] & $past(reg_wdata)) == '0));

    // R7
    event_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq);

    // R9
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!irq && pin_oe == '0 && stat_q == '0));
endmodule

bind pinbank_irq_ctrl pinbank_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_oe(pin_oe),
    .irq(irq), .stat_q(stat_q), .evt(evt)
);

// File: tb/pinbank_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pinbank_irq_ctrl_tb_top;
    localparam int NP = 70;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_out;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    pinbank_irq_ctrl #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    // reference state
    logic [NP-1:0] m_oe, m_drv, m_pol, m_typ, m_stat, m_s1, m_s2, m_s3;
    logic [NP-1:0] m_ien [4];
    logic [NP-1:0] cur_pins = '0;

    localparam logic [7:0] A_OE = 8'h05, A_DRV = 8'h09, A_IEN = 8'h11,
                           A_POL = 8'h41, A_TYP = 8'h45, A_ST = 8'h49;

    function automatic int bank_of(logic [7:0] a, logic [7:0] base);
        if (a >= base && a < base + 8'd3) return int'(a - base);
        return -1;
    endfunction

    function automatic logic [NP-1:0] merge(logic [NP-1:0] old, int b, logic [31:0] d);
        logic [NP-1:0] r = old;
        for (int i = 0; i < NP; i++) if (i / 32 == b) r[i] = d[i % 32];
        return r;
    endfunction

    function automatic logic [31:0] pick(logic [NP-1:0] v, int b);
        logic [95:0] p = '0;
        p[NP-1:0] = v;
        return p[b*32 +: 32];
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (bank_of(a, A_OE)  >= 0) return pick(m_oe,  bank_of(a, A_OE));
        if (bank_of(a, A_DRV) >= 0) return pick(m_drv, bank_of(a, A_DRV));
        if (bank_of(a, A_POL) >= 0) return pick(m_pol, bank_of(a, A_POL));
        if (bank_of(a, A_TYP) >= 0) return pick(m_typ, bank_of(a, A_TYP));
        if (bank_of(a, A_ST)  >= 0) return pick(m_stat, bank_of(a, A_ST));
        for (int s = 0; s < 4; s++)
            if (bank_of(a, A_IEN + 8'(4*s)) >= 0)
                return pick(m_ien[s], bank_of(a, A_IEN + 8'(4*s)));
        return 32'h0;
    endfunction

    function automatic logic [NP-1:0] calc_ev();
        logic [NP-1:0] e;
        for (int i = 0; i < NP; i++) begin
            case ({m_typ[i], m_pol[i]})
                2'b00: e[i] = m_s2[i];
                2'b01: e[i] = ~m_s2[i];
                2'b10: e[i] = m_s2[i] & ~m_s3[i];
                default: e[i] = ~m_s2[i] & m_s3[i];
            endcase
        end
        return e;
    endfunction

    task automatic mdl_write(logic [7:0] a, logic [31:0] d);
        if (bank_of(a, A_OE)  >= 0) m_oe  = merge(m_oe,  bank_of(a, A_OE),  d);
        if (bank_of(a, A_DRV) >= 0) m_drv = merge(m_drv, bank_of(a, A_DRV), d);
        if (bank_of(a, A_POL) >= 0) m_pol = merge(m_pol, bank_of(a, A_POL), d);
        if (bank_of(a, A_TYP) >= 0) m_typ = merge(m_typ, bank_of(a, A_TYP), d);
        if (bank_of(a, A_ST)  >= 0) m_stat = m_stat & ~merge('0, bank_of(a, A_ST), d);
        for (int s = 0; s < 4; s++)
            if (bank_of(a, A_IEN + 8'(4*s)) >= 0)
                m_ien[s] = merge(m_ien[s], bank_of(a, A_IEN + 8'(4*s)), d);
    endtask

    task automatic mdl_reset();
        m_oe = '0; m_drv = '0; m_pol = '0; m_typ = '0; m_stat = '0;
        m_s1 = '0; m_s2 = '0; m_s3 = '0;
        for (int s = 0; s < 4; s++) m_ien[s] = '0;
    endtask

    task automatic step(logic we, logic [7:0] a, logic [31:0] d);
        logic [NP-1:0] ev;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; pin_in = cur_pins;
        @(posedge clk);
        ev = calc_ev();
        if (we) mdl_write(a, d);
        m_stat = m_stat | ev;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = cur_pins;
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic rd(string tag, logic [7:0] a);
        step(1'b0, a, 32'h0);
        chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1'b1, a, d);
    endtask

    function automatic logic [7:0] rand_addr();
        logic [7:0] bases [9] = '{A_OE, A_DRV, A_POL, A_TYP, A_ST, A_IEN,
                                  A_IEN + 8'd4, A_IEN + 8'd8, A_IEN + 8'd12};
        return bases[$urandom_range(0, 8)] + 8'($urandom_range(0, 2));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mdl_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R9: everything clear after reset
        chk("R9 irq", {31'h0, irq}, 32'h0);
        chk("R9 pin_oe", pick(pin_oe, 2) | pick(pin_oe, 0), 32'h0);
        for (int b = 0; b < 3; b++) begin
            rd("R9 status", A_ST + 8'(b));
            rd("R9 type", A_TYP + 8'(b));
        end

        // R1 R2: configuration write and read-back
        for (int k = 0; k < 60; k++) begin
            logic [7:0]  a = rand_addr();
            logic [31:0] d = $urandom;
            if (bank_of(a, A_ST) >= 0) continue;
            wr(a, d);
            rd("R1 R2 readback", a);
        end
        chk("R2 pin_oe bank0", pick(pin_oe, 0), pick(m_oe, 0));
        chk("R2 pin_out bank1", pick(pin_out, 1), pick(m_drv, 1));

        // R3: upper pins absent
        wr(A_OE + 8'd2, 32'hFFFF_FFFF);
        rd("R3 oe bank2", A_OE + 8'd2);
        chk("R3 oe bank2 value", reg_rdata, 32'h0000_003F);
        chk("R3 pin_oe top", {26'h0, pin_oe[69:64]}, 32'h3F);

        // R1: unmapped addresses
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd("R1 unmapped 0x08", 8'h08);
        chk("R1 unmapped value", reg_rdata, 32'h0);
        rd("R1 unmapped 0x10", 8'h10);
        rd("R1 neighbour intact", A_OE + 8'd2);

        // R4 R5 R6 R8: random traffic
        for (int k = 0; k < 3000; k++) begin
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0)
                cur_pins = cur_pins ^ (NP'(1) << $urandom_range(0, NP-1)) ^ {$urandom, $urandom, $urandom};
            if (op == 0) wr(A_POL + 8'($urandom_range(0, 2)), $urandom);
            else if (op == 1) wr(A_TYP + 8'($urandom_range(0, 2)), $urandom);
            else if (op == 2) wr(A_IEN + 8'(4 * $urandom_range(0, 3)) + 8'($urandom_range(0, 2)), $urandom);
            else if (op == 3) wr(A_ST + 8'($urandom_range(0, 2)), $urandom);
            else rd("R4 R5 R6 random", (op > 6) ? A_ST + 8'($urandom_range(0, 2)) : rand_addr());
            chk("R8 irq random", {31'h0, irq}, {31'h0, |(m_stat & m_ien[0])});
        end

        // quiet setup: level high, pins low, enables off, status cleared
        cur_pins = '0;
        for (int b = 0; b < 3; b++) begin
            wr(A_TYP + 8'(b), 32'h0); wr(A_POL + 8'(b), 32'h0);
            for (int s = 0; s < 4; s++) wr(A_IEN + 8'(4*s) + 8'(b), 32'h0);
        end
        repeat (3) step(1'b0, 8'h00, 32'h0);
        for (int b = 0; b < 3; b++) wr(A_ST + 8'(b), 32'hFFFF_FFFF);
        rd("R6 all cleared", A_ST);
        chk("R6 all cleared value", reg_rdata, 32'h0);

        // R4 R5: rising edge on pin 3, exact timing
        wr(A_TYP, 32'h8);
        wr(A_IEN, 32'h8);
        cur_pins[3] = 1'b1;
        rd("R4 edge 1", A_ST);
        chk("R4 not yet 1", reg_rdata, 32'h0);
        rd("R4 edge 2", A_ST);
        chk("R4 not yet 2", reg_rdata, 32'h0);
        rd("R4 edge 3", A_ST);
        chk("R4 rise seen", reg_rdata, 32'h8);
        chk("R8 irq on", {31'h0, irq}, 32'h1);
        // R6: write 0 keeps, write 1 clears
        wr(A_ST, 32'h0);
        rd("R6 zero write", A_ST);
        chk("R6 zero write value", reg_rdata, 32'h8);
        wr(A_ST, 32'h8);
        rd("R6 cleared", A_ST);
        chk("R6 cleared value", reg_rdata, 32'h0);
        chk("R8 irq off", {31'h0, irq}, 32'h0);

        // R5: falling edge on pin 3
        wr(A_POL, 32'h8);
        cur_pins[3] = 1'b0;
        repeat (3) rd("R5 fall", A_ST);
        chk("R5 fall seen", reg_rdata, 32'h8);

        // R7: level high on pin 69 survives a clear
        cur_pins[69] = 1'b1;
        repeat (3) rd("R7 level", A_ST + 8'd2);
        chk("R7 level set", reg_rdata, 32'h20);
        wr(A_ST + 8'd2, 32'h20);
        rd("R7 after clear", A_ST + 8'd2);
        chk("R7 level persists", reg_rdata, 32'h20);

        // R8: enable set 1 alone does not raise irq
        wr(A_ST, 32'hFFFF_FFFF);
        wr(A_IEN, 32'h0);
        wr(A_IEN + 8'd4 + 8'd2, 32'hFFFF_FFFF);
        rd("R8 set1", A_IEN + 8'd6);
        chk("R8 set1 no irq", {31'h0, irq}, 32'h0);
        wr(A_IEN + 8'd2, 32'h20);
        rd("R8 set0", A_ST + 8'd2);
        chk("R8 set0 irq", {31'h0, irq}, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_fail);
        $finish;
    end
endmodule